// File: doc/BRIEF.md
# Bus-Clamped Five-Segment Space-Vector Sequencer

This block drives the six switches of a two-level three-phase inverter through space-vector modulation, given pre-computed timing. For every sampling period it takes a sector number, the dwell times of the two active vectors adjacent to the reference, the period length (all in clock ticks) and a clamp-side select. It then plays out a five-segment switching pattern that uses only one of the two zero vectors. The pole that is common to that zero vector and both active vectors stays tied to one DC rail for the whole period. This removes one third of the switch transitions compared with the seven-segment pattern.

The sequencer runs continuously from reset, one period after another. Each period is marked by a done strobe on its last tick. Overmodulated requests are clipped by dropping the zero vector and are flagged for the duration of that period. Angle-to-dwell-time arithmetic and dead-time insertion belong to neighbouring blocks.

Top module: `clamp_svm_seq`

## Requirements
- R1: The 3-bit state is {pole A, pole B, pole C}, with vectors coded V0=000, V1=100, V2=110, V3=010, V4=011, V5=001, V6=101, V7=111. With `max_clamp`=0 the five segments per sector are: sector 1 V0 V1 V2 V1 V0; sector 2 V0 V3 V2 V3 V0; sector 3 V0 V3 V4 V3 V0; sector 4 V0 V5 V4 V5 V0; sector 5 V0 V5 V6 V5 V0; sector 6 V0 V1 V6 V1 V0. Sector codes 0 and 7 are treated as sector 1.
- R2: With `max_clamp`=1 the sequences are: sector 1 V7 V2 V1 V2 V7; sector 2 V7 V2 V3 V2 V7; sector 3 V7 V4 V3 V4 V7; sector 4 V7 V4 V5 V4 V7; sector 5 V7 V6 V5 V6 V7; sector 6 V7 V6 V1 V6 V7.
- R3: Segment 0 to segment 4 last floor(T0/2), floor(T1/2), T2, T1-floor(T1/2) and T0-floor(T0/2) ticks, where T0 = Ts-T1-T2. A period without overmodulation therefore lasts exactly Ts ticks. `seg_idx` shows the segment number 0 to 4.
- R4: In min-clamp mode the state 111 never appears, and one pole is 0 on every tick of the period. In max-clamp mode the state 000 never appears, and one pole is 1 on every tick of the period.
- R5: Sector, T1, T2, Ts and the clamp select are sampled only at the clock edge that starts a period. Changes during a period do not alter that period.
- R6: When T1+T2 > Ts, T0 is taken as 0, the period lasts T1+T2 ticks, and `overmod` is 1 on every tick of that period. When T1+T2 = Ts, `overmod` is 0.
- R7: Segments of zero duration are skipped, and their state never appears even for one tick. If all five durations are zero, the period is one tick of segment 0.
- R8: When all five durations are nonzero, each change of state within a period flips exactly one pole.
- R9: `period_done` is 1 on the last tick of each period and only then. The next period's first segment appears on the following tick.
- R10: While reset is asserted, and until the first clock edge after its release, the outputs are `sw_state`=000, `seg_idx`=0, `period_done`=0 and `overmod`=0. That first edge starts the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector | input | 3 | Sector 1 to 6 of the reference vector |
| t1_ticks | input | TW | Dwell of the first active vector, in ticks |
| t2_ticks | input | TW | Dwell of the second active vector, in ticks |
| ts_ticks | input | TW | Sampling period length, in ticks |
| max_clamp | input | 1 | 0: clamp to negative rail (V0 only), 1: clamp to positive rail (V7 only) |
| sw_state | output | 3 | Current switching state {A,B,C}, 1 = upper switch on |
| seg_idx | output | 3 | Current segment number 0 to 4 |
| period_done | output | 1 | High on the last tick of a period |
| overmod | output | 1 | High for every tick of an overmodulated period |

## Verification
Inputs are sampled at the edge that opens a period, and the first tick of that period is visible right after that same edge. The bench therefore loads new inputs on the falling edge where `period_done` is seen high, and reads one tick per following falling edge until the next strobe. Each recorded tick is compared against a trace of states and segment numbers built from the duration formulas, so skipped segments, period length and the overmodulation flag are all checked at tick resolution. For the reset value checks the bench looks at the outputs before the first edge after release, and again immediately after an asynchronous reset in mid-period.

// File: rtl/clamp_svm_seq.sv
module clamp_svm_seq #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sector,
  input  logic [TW-1:0] t1_ticks,
  input  logic [TW-1:0] t2_ticks,
  input  logic [TW-1:0] ts_ticks,
  input  logic          max_clamp,
  output logic [2:0]    sw_state,
  output logic [2:0]    seg_idx,
  output logic          period_done,
  output logic          overmod
);

  localparam logic [2:0] NONE = 3'd5;

  logic          run;
  logic [2:0]    sec_q;
  logic          max_q;
  logic [2:0]    seg_q;
  logic [TW-1:0] left_q;
  logic [TW-1:0] dur_q [5];

  logic [TW:0]   act_sum;
  logic          ovm_n;
  logic [TW-1:0] t0_n;
  logic [2:0]    sec_n;
  logic [TW-1:0] nd [5];
  logic [2:0]    first_n;
  logic [2:0]    nxt_seg;
  logic          last;

  assign act_sum = {1'b0, t1_ticks} + {1'b0, t2_ticks};
  assign ovm_n   = act_sum > {1'b0, ts_ticks};
  assign t0_n    = ovm_n ? '0 : ts_ticks - t1_ticks - t2_ticks;
  assign sec_n   = (sector == 3'd0 || sector == 3'd7) ? 3'd1 : sector;

  always_comb begin
    nd[0] = t0_n >> 1;
    nd[1] = t1_ticks >> 1;
    nd[2] = t2_ticks;
    nd[3] = t1_ticks - (t1_ticks >> 1);
    nd[4] = t0_n - (t0_n >> 1);
    if (t0_n == '0 && t1_ticks == '0 && t2_ticks == '0) nd[0] = TW'(1);
    first_n = NONE;
    for (int i = 4; i >= 0; i--)
      if (nd[i] != '0) first_n = 3'(i);
  end

  always_comb begin
    nxt_seg = NONE;
    for (int i = 4; i >= 0; i--)
      if (3'(i) > seg_q && dur_q[i] != '0) nxt_seg = 3'(i);
  end

  assign last        = (left_q == TW'(1)) && (nxt_seg == NONE);
  assign period_done = run && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      sec_q   <= 3'd1;
      max_q   <= 1'b0;
      seg_q   <= 3'd0;
      left_q  <= '0;
      overmod <= 1'b0;
      for (int i = 0; i < 5; i++) dur_q[i] <= '0;
    end else if (!run || last) begin
      run     <= 1'b1;
      sec_q   <= sec_n;
      max_q   <= max_clamp;
      overmod <= ovm_n;
      for (int i = 0; i < 5; i++) dur_q[i] <= nd[i];
      seg_q   <= first_n;
      left_q  <= nd[first_n];
    end else if (left_q == TW'(1)) begin
      seg_q  <= nxt_seg;
      left_q <= dur_q[nxt_seg];
    end else begin
      left_q <= left_q - TW'(1);
    end
  end

  function automatic logic [2:0] vec_code(input logic [2:0] v);
    case (v)
      3'd1:    vec_code = 3'b100;
      3'd2:    vec_code = 3'b110;
      3'd3:    vec_code = 3'b010;
      3'd4:    vec_code = 3'b011;
      3'd5:    vec_code = 3'b001;
      3'd6:    vec_code = 3'b101;
      3'd7:    vec_code = 3'b111;
      default: vec_code = 3'b000;
    endcase
  endfunction

  logic [2:0] hi_v, odd_v, even_v, outer_v, mid_v, zero_v, pick_v;

  assign hi_v    = (sec_q == 3'd6) ? 3'd1 : sec_q + 3'd1;
  assign odd_v   = sec_q[0] ? sec_q : hi_v;
  assign even_v  = sec_q[0] ? hi_v : sec_q;
  assign outer_v = max_q ? even_v : odd_v;
  assign mid_v   = max_q ? odd_v : even_v;
  assign zero_v  = max_q ? 3'd7 : 3'd0;

  always_comb begin
    case (seg_q)
      3'd1, 3'd3: pick_v = outer_v;
      3'd2:       pick_v = mid_v;
      default:    pick_v = zero_v;
    endcase
  end

  assign sw_state = run ? vec_code(pick_v) : 3'b000;
  assign seg_idx  = seg_q;

endmodule

// File: rtl/clamp_svm_seq_chk.sv
module clamp_svm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sw_state,
  input logic [2:0] seg_idx,
  input logic       period_done,
  input logic       overmod,
  input logic       max_q,
  input logic       run
);

  p_seg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= 3'd4);

  p_min_no_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !max_q) |-> (sw_state != 3'b111));

  p_max_no_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && max_q) |-> (sw_state != 3'b000));

  p_ovm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(period_done)) |-> $stable(overmod));

  p_seg_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(period_done)) |-> (seg_idx >= $past(seg_idx)));

  p_step_small_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(period_done))
      |-> ($countones(sw_state ^ $past(sw_state)) <= 2));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!period_done && sw_state == 3'b000));

endmodule

bind clamp_svm_seq clamp_svm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_state(sw_state), .seg_idx(seg_idx),
  .period_done(period_done), .overmod(overmod), .max_q(max_q), .run(run)
);

// File: tb/clamp_svm_seq_tb.sv
module clamp_svm_seq_tb;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sector = 3'd1;
  logic [TW-1:0] t1_ticks = '0, t2_ticks = '0, ts_ticks = '0;
  logic max_clamp = 1'b0;
  logic [2:0] sw_state, seg_idx;
  logic period_done, overmod;

  always #10 clk = ~clk;

  clamp_svm_seq #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sector(sector), .t1_ticks(t1_ticks),
    .t2_ticks(t2_ticks), .ts_ticks(ts_ticks), .max_clamp(max_clamp),
    .sw_state(sw_state), .seg_idx(seg_idx), .period_done(period_done),
    .overmod(overmod)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // {sector, max, t1, t2, ts, seg0..seg4 states, overmod}
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {3'd1, 1'b0, 8'd4, 8'd6, 8'd20, 15'b000_100_110_100_000, 1'b0},
    {3'd2, 1'b0, 8'd3, 8'd5, 8'd16, 15'b000_010_110_010_000, 1'b0},
    {3'd3, 1'b0, 8'd6, 8'd2, 8'd12, 15'b000_010_011_010_000, 1'b0},
    {3'd4, 1'b1, 8'd2, 8'd2, 8'd10, 15'b111_011_001_011_111, 1'b0},
    {3'd5, 1'b1, 8'd5, 8'd3, 8'd14, 15'b111_101_001_101_111, 1'b0},
    {3'd6, 1'b0, 8'd4, 8'd4, 8'd12, 15'b000_100_101_100_000, 1'b0},
    {3'd6, 1'b1, 8'd1, 8'd3, 8'd9,  15'b111_101_100_101_111, 1'b0},
    {3'd1, 1'b1, 8'd0, 8'd4, 8'd8,  15'b111_110_100_110_111, 1'b0},
    {3'd4, 1'b0, 8'd0, 8'd0, 8'd6,  15'b000_001_011_001_000, 1'b0},
    {3'd2, 1'b1, 8'd8, 8'd9, 8'd12, 15'b111_110_010_110_111, 1'b1},
    {3'd3, 1'b1, 8'd5, 8'd5, 8'd10, 15'b111_011_010_011_111, 1'b0},
    {3'd5, 1'b0, 8'd7, 8'd0, 8'd7,  15'b000_001_101_001_000, 1'b0},
    {3'd1, 1'b0, 8'd0, 8'd0, 8'd0,  15'b000_100_110_100_000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called on a falling edge where a new period will start at the next rising edge.
  task automatic run_period(input int sec, input bit mx, input int a, input int b,
                            input int p, input logic [14:0] sq, input bit eovm,
                            input bit mid, input string tag);
    int d[5];
    int t0, m, n, bad, ebad;
    logic [2:0] es[64], eg[64], as_[64], ag[64];
    bit ad[64], ao[64];
    logic [2:0] orv, andv;
    bit allnz;
    sector = 3'(sec); max_clamp = mx;
    t1_ticks = TW'(a); t2_ticks = TW'(b); ts_ticks = TW'(p);
    t0 = (a + b > p) ? 0 : p - a - b;
    d[0] = t0 / 2; d[1] = a / 2; d[2] = b; d[3] = a - a / 2; d[4] = t0 - t0 / 2;
    if (t0 == 0 && a == 0 && b == 0) d[0] = 1;
    m = 0;
    for (int s = 0; s < 5; s++)
      for (int k = 0; k < d[s]; k++) begin
        if (m < 64) begin es[m] = sq[14 - 3*s -: 3]; eg[m] = 3'(s); end
        m++;
      end
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      as_[n] = sw_state; ag[n] = seg_idx; ad[n] = period_done; ao[n] = overmod;
      n++;
      if (mid && n == 2) begin
        sector = 3'(sec % 6 + 1); max_clamp = ~mx;
        t1_ticks = TW'(a + 3); t2_ticks = '0; ts_ticks = TW'(p + 5);
      end
    end while (!period_done && n < 64);

    check(n == m, tag, "period length", n, m);
    bad = -1;
    for (int k = 0; k < n && k < m; k++)
      if (bad < 0 && (as_[k] !== es[k] || ag[k] !== eg[k])) bad = k;
    if (bad >= 0)
      check(1'b0, tag, $sformatf("state/segment at tick %0d", bad),
            {ag[bad], as_[bad]}, {eg[bad], es[bad]});
    else check(1'b1, tag, "trace", 0, 0);
    ebad = 0;
    for (int k = 0; k < n; k++) if (ao[k] !== eovm) ebad++;
    check(ebad == 0, "R6", $sformatf("overmod on %0d ticks", n), ebad, 0);
    ebad = 0;
    for (int k = 0; k < n; k++) if (ad[k] !== (k == n - 1)) ebad++;
    check(ebad == 0, "R9", "done strobe only on last tick", ebad, 0);
    orv = '0; andv = 3'b111;
    for (int k = 0; k < n; k++) begin orv |= as_[k]; andv &= as_[k]; end
    if (mx) check(andv != 3'b000, "R4", "pole held at 1", int'(andv), 1);
    else    check(orv != 3'b111,  "R4", "pole held at 0", int'(orv), 6);
    allnz = (d[0] > 0 && d[1] > 0 && d[2] > 0 && d[3] > 0 && d[4] > 0);
    if (allnz) begin
      ebad = 0;
      for (int k = 1; k < n; k++)
        if (as_[k] != as_[k-1] && $countones(as_[k] ^ as_[k-1]) != 1) ebad++;
      check(ebad == 0, "R8", "multi-pole steps", ebad, 0);
    end
  endtask

  function automatic string vtag(input int i);
    if (i == 9) return "R6";
    if (i == 6 || i == 7 || i == 8 || i == 11 || i == 12) return "R7";
    return VEC[i][39] ? "R2/R3" : "R1/R3";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sw_state == 3'b000 && seg_idx == 3'd0 && !period_done && !overmod,
          "R10", "outputs in reset", {seg_idx, sw_state, period_done, overmod}, 0);
    rst_n = 1'b1;
    #1;
    check(sw_state == 3'b000 && seg_idx == 3'd0 && !period_done,
          "R10", "outputs before first edge", {seg_idx, sw_state, period_done}, 0);

    for (int i = 0; i < NV; i++)
      run_period(int'(VEC[i][43:41]), VEC[i][40], int'(VEC[i][39:32]),
                 int'(VEC[i][31:24]), int'(VEC[i][23:16]), VEC[i][15:1],
                 VEC[i][0], 1'b0, vtag(i));

    // R5: inputs altered during a period leave it untouched
    run_period(3, 0, 4, 4, 16, 15'b000_010_011_010_000, 1'b0, 1'b1, "R5");
    run_period(3, 1, 4, 4, 16, 15'b111_011_010_011_111, 1'b0, 1'b0, "R5");
    // R1: out-of-range sector code treated as sector 1
    run_period(7, 0, 2, 2, 8, 15'b000_100_110_100_000, 1'b0, 1'b0, "R1");

    // R10: asynchronous reset mid-period, then restart on first edge
    sector = 3'd2; max_clamp = 1'b1;
    t1_ticks = TW'(4); t2_ticks = TW'(4); ts_ticks = TW'(20);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sw_state == 3'b000 && seg_idx == 3'd0 && !period_done && !overmod,
          "R10", "outputs after mid-period reset", {seg_idx, sw_state}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_period(2, 1, 4, 4, 20, 15'b111_110_010_110_111, 1'b0, 1'b0, "R10");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule